// File: doc/BRIEF.md
# Single-Precision Minimum/Maximum Unit with NaN Rules

This unit takes two single-precision floating-point operands and returns their maximum, their minimum, or the NaN-ignoring form of either, chosen by a 2-bit opcode. Before any comparison each operand is sorted into one of five classes: zero, nonzero (denormals included), infinity, quiet NaN or signalling NaN. NaN operands take precedence over the comparison. A signalling NaN is always quieted and raises an invalid-operation event. A default-NaN control input can force every NaN result to one canonical pattern.

Ordinary operands are compared by numeric value. When neither operand wins strictly, the second operand is chosen. A zero result gets its sign from both operand signs: AND for maximum, OR for minimum. The NaN-ignoring variants replace a lone quiet NaN with the infinity that always loses the comparison.

Invalid-operation events go to one of two places. If the trap enable is clear, they set a sticky status flag, which only an explicit clear input resets. If the trap enable is set, they produce a one-cycle trap strobe instead. Every result is registered and appears one cycle after the request.

Top module: `fp_minmax_unit`

## Requirements
- R1: `opcode` selects the operation: 0 = maximum, 1 = minimum, 2 = NaN-ignoring maximum, 3 = NaN-ignoring minimum. A request with `in_vld` high shows up on `res_o` with `res_vld_o` high exactly one clock later. Without a request, `res_vld_o` is low and `res_o` holds its last value.
- R2: With no NaN involved, maximum returns the operand with the larger numeric value and minimum the smaller one. Denormals are ordered by their value, and an infinity comes out with its own sign.
- R3: If the two operands compare equal, the second one is selected. If the result is a zero, its sign bit is the AND of both operand signs for maximum and the OR for minimum (so max(+0,−0)=+0 and min(+0,−0)=−0).
- R4: If any operand is a NaN, the result is a NaN taken from the first match in this list: operand 1 signalling, operand 2 signalling, operand 1 quiet, operand 2 quiet. A quiet NaN has exponent all ones and fraction bit 22 set. A signalling NaN has exponent all ones, bit 22 clear and a nonzero fraction.
- R5: A selected signalling NaN comes out with bit 22 set and every other bit unchanged. A selected quiet NaN passes through bit for bit.
- R6: While `dn_mode` is high, every NaN result is replaced by 0x7FC00000.
- R7: In the NaN-ignoring variants, if exactly one operand is a quiet NaN, it is replaced before the rules above: by −infinity (0xFF800000) for maximum and by +infinity (0x7F800000) for minimum. If both operands are quiet NaNs, no replacement takes place. A signalling NaN is never replaced.
- R8: An invalid-operation event occurs when an accepted request has at least one signalling NaN operand. With `inv_trap_en` low, the event sets `flags_o[0]` at the same edge as the result. Bits above bit 0 of `flags_o` stay 0.
- R9: With `inv_trap_en` high, an invalid-operation event drives `trap_o` high for exactly the one cycle in which the result is valid, and leaves `flags_o` unchanged.
- R10: `flags_o` is sticky. It is cleared only by `flag_clr`. If a clear and a new event fall on the same edge, the flag ends up set.
- R11: During reset, `res_o`, `res_vld_o`, `trap_o` and `flags_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Request strobe |
| opa | input | 32 | Operand 1 |
| opb | input | 32 | Operand 2 |
| opcode | input | 2 | Operation select |
| dn_mode | input | 1 | Default-NaN mode |
| inv_trap_en | input | 1 | Trap enable for invalid operation |
| flag_clr | input | 1 | Clears the sticky flags |
| res_o | output | 32 | Registered result |
| res_vld_o | output | 1 | Result valid |
| trap_o | output | 1 | Trap request strobe |
| flags_o | output | FLAG_W | Sticky status flags, bit 0 = invalid operation |

## Verification
The bench goes after the following corner cases:
- Signed zeros compared against each other. A unit that simply passes the selected zero through would return −0 from max(+0,−0).
- Pairs of NaNs that differ in kind and position. A wrong priority order would return the quiet NaN's payload where the signalling one should win, or operand 2 where operand 1 should.
- NaN-ignoring requests with one quiet NaN facing a signalling NaN or an infinity. Substituting the wrong infinity, or replacing a signalling NaN, gives a number where a NaN belongs, or the reverse.
- The flag path with trap enabled, flag clear and both on the same cycle. A flag that drops or a trap that lasts two cycles shows up as a mismatch.

// File: rtl/fmm_pkg.sv
package fmm_pkg;

  localparam int WORD_W    = 32;
  localparam int EXP_W     = 8;
  localparam int FRAC_W    = WORD_W - 1 - EXP_W;
  localparam int QUIET_BIT = FRAC_W - 1;

  localparam logic [WORD_W-1:0] CANON_NAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
  localparam logic [WORD_W-1:0] POS_INF   = {1'b0, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
  localparam logic [WORD_W-1:0] NEG_INF   = {1'b1, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};

  typedef enum logic [2:0] {
    CLS_ZERO = 3'd0,
    CLS_NUM  = 3'd1,
    CLS_INF  = 3'd2,
    CLS_QNAN = 3'd3,
    CLS_SNAN = 3'd4
  } fcls_e;

  // Sort key: unsigned order of the key equals numeric order of the value,
  // with both zeros mapped to the same key.
  function automatic logic [WORD_W-1:0] order_key(input logic [WORD_W-1:0] w,
                                                  input logic              is_zero);
    logic [WORD_W-1:0] k;
    if (is_zero)
      k = {1'b1, {(WORD_W-1){1'b0}}};
    else if (w[WORD_W-1])
      k = ~w;
    else
      k = {1'b1, w[WORD_W-2:0]};
    return k;
  endfunction

endpackage

// File: rtl/fmm_classify.sv
module fmm_classify
  import fmm_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output fcls_e             cls_o
);

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;

  assign exp_f  = word_i[WORD_W-2 -: EXP_W];
  assign frac_f = word_i[FRAC_W-1:0];

  always_comb begin
    if (exp_f == '0) begin
      cls_o = (frac_f == '0) ? CLS_ZERO : CLS_NUM;
    end else if (exp_f == '1) begin
      if (frac_f == '0)
        cls_o = CLS_INF;
      else if (frac_f[QUIET_BIT])
        cls_o = CLS_QNAN;
      else
        cls_o = CLS_SNAN;
    end else begin
      cls_o = CLS_NUM;
    end
  end

endmodule

// File: rtl/fmm_nan_pick.sv
module fmm_nan_pick
  import fmm_pkg::*;
(
  input  logic [WORD_W-1:0] a_w,
  input  logic [WORD_W-1:0] b_w,
  input  fcls_e             a_cls,
  input  fcls_e             b_cls,
  input  logic              dn_mode,
  output logic              is_nan_o,
  output logic [WORD_W-1:0] nan_w_o,
  output logic              invalid_o
);

  logic [WORD_W-1:0] picked;
  logic [WORD_W-1:0] quiet_mask;

  assign quiet_mask = {{(WORD_W-QUIET_BIT-1){1'b0}}, 1'b1, {QUIET_BIT{1'b0}}};

  always_comb begin
    is_nan_o  = 1'b1;
    invalid_o = 1'b0;
    picked    = '0;
    if (a_cls == CLS_SNAN) begin
      picked    = a_w | quiet_mask;
      invalid_o = 1'b1;
    end else if (b_cls == CLS_SNAN) begin
      picked    = b_w | quiet_mask;
      invalid_o = 1'b1;
    end else if (a_cls == CLS_QNAN) begin
      picked    = a_w;
    end else if (b_cls == CLS_QNAN) begin
      picked    = b_w;
    end else begin
      is_nan_o  = 1'b0;
    end
    nan_w_o = dn_mode ? CANON_NAN : picked;
  end

endmodule

// File: rtl/fmm_order.sv
module fmm_order
  import fmm_pkg::*;
(
  input  logic [WORD_W-1:0] a_w,
  input  logic [WORD_W-1:0] b_w,
  input  fcls_e             a_cls,
  input  fcls_e             b_cls,
  input  logic              take_min,
  output logic [WORD_W-1:0] sel_w_o
);

  logic [WORD_W-1:0] key_a;
  logic [WORD_W-1:0] key_b;
  logic              a_wins;
  logic [WORD_W-1:0] chosen;
  fcls_e             chosen_cls;
  logic              zero_sign;

  assign key_a = order_key(a_w, a_cls == CLS_ZERO);
  assign key_b = order_key(b_w, b_cls == CLS_ZERO);

  // strict win for operand 1; ties go to operand 2
  assign a_wins = take_min ? (key_a < key_b) : (key_a > key_b);

  always_comb begin
    chosen     = a_wins ? a_w : b_w;
    chosen_cls = a_wins ? a_cls : b_cls;
    zero_sign  = take_min ? (a_w[WORD_W-1] | b_w[WORD_W-1])
                          : (a_w[WORD_W-1] & b_w[WORD_W-1]);
    if (chosen_cls == CLS_ZERO)
      sel_w_o = {zero_sign, {(WORD_W-1){1'b0}}};
    else
      sel_w_o = chosen;
  end

endmodule

// File: rtl/fmm_flag_reg.sv
module fmm_flag_reg #(
  parameter int FLAG_W  = 5,
  parameter int INV_BIT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inv_evt,
  input  logic              trap_en,
  input  logic              clr,
  output logic [FLAG_W-1:0] flags_o,
  output logic              trap_o
);

  logic [FLAG_W-1:0] flags_q, flags_d;
  logic              trap_q, trap_d;
  logic [FLAG_W-1:0] set_vec;

  always_comb begin
    set_vec          = '0;
    set_vec[INV_BIT] = inv_evt & ~trap_en;
    trap_d           = inv_evt & trap_en;
    flags_d          = (clr ? '0 : flags_q) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      trap_q  <= 1'b0;
    end else begin
      flags_q <= flags_d;
      trap_q  <= trap_d;
    end
  end

  assign flags_o = flags_q;
  assign trap_o  = trap_q;

endmodule

// File: rtl/fp_minmax_unit.sv
module fp_minmax_unit
  import fmm_pkg::*;
#(
  parameter int FLAG_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [WORD_W-1:0] opa,
  input  logic [WORD_W-1:0] opb,
  input  logic [1:0]        opcode,
  input  logic              dn_mode,
  input  logic              inv_trap_en,
  input  logic              flag_clr,
  output logic [WORD_W-1:0] res_o,
  output logic              res_vld_o,
  output logic              trap_o,
  output logic [FLAG_W-1:0] flags_o
);

  localparam int N_OPS   = 2;
  localparam int INV_BIT = 0;

  logic              ignore_nan;
  logic              take_min;
  logic [WORD_W-1:0] raw_w [N_OPS];
  logic [WORD_W-1:0] adj_w [N_OPS];
  fcls_e             raw_cls [N_OPS];
  fcls_e             adj_cls [N_OPS];

  assign ignore_nan = opcode[1];
  assign take_min   = opcode[0];
  assign raw_w[0]   = opa;
  assign raw_w[1]   = opb;

  // classify raw operands, substitute a lone quiet NaN, classify again
  for (genvar g = 0; g < N_OPS; g++) begin : g_opnd
    localparam int OTHER = N_OPS - 1 - g;
    logic lone_q;

    fmm_classify u_raw_cls (
      .word_i (raw_w[g]),
      .cls_o  (raw_cls[g])
    );

    assign lone_q   = ignore_nan && (raw_cls[g] == CLS_QNAN) && (raw_cls[OTHER] != CLS_QNAN);
    assign adj_w[g] = lone_q ? (take_min ? POS_INF : NEG_INF) : raw_w[g];

    fmm_classify u_adj_cls (
      .word_i (adj_w[g]),
      .cls_o  (adj_cls[g])
    );
  end

  logic              is_nan;
  logic [WORD_W-1:0] nan_w;
  logic              invalid;
  logic [WORD_W-1:0] ord_w;

  fmm_nan_pick u_nan (
    .a_w       (adj_w[0]),
    .b_w       (adj_w[1]),
    .a_cls     (adj_cls[0]),
    .b_cls     (adj_cls[1]),
    .dn_mode   (dn_mode),
    .is_nan_o  (is_nan),
    .nan_w_o   (nan_w),
    .invalid_o (invalid)
  );

  fmm_order u_ord (
    .a_w      (adj_w[0]),
    .b_w      (adj_w[1]),
    .a_cls    (adj_cls[0]),
    .b_cls    (adj_cls[1]),
    .take_min (take_min),
    .sel_w_o  (ord_w)
  );

  // result register with written-out enable
  logic [WORD_W-1:0] res_q, res_d;
  logic              vld_q, vld_d;
  logic              res_en;

  always_comb begin
    res_en = in_vld;
    vld_d  = in_vld;
    res_d  = is_nan ? nan_w : ord_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      if (res_en)
        res_q <= res_d;
    end
  end

  fmm_flag_reg #(
    .FLAG_W  (FLAG_W),
    .INV_BIT (INV_BIT)
  ) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .inv_evt (in_vld & invalid),
    .trap_en (inv_trap_en),
    .clr     (flag_clr),
    .flags_o (flags_o),
    .trap_o  (trap_o)
  );

  assign res_o     = res_q;
  assign res_vld_o = vld_q;

endmodule

// File: rtl/fp_minmax_unit_chk.sv
module fp_minmax_unit_chk
  import fmm_pkg::*;
#(
  parameter int FLAG_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_vld,
  input logic              dn_mode,
  input logic              inv_trap_en,
  input logic              flag_clr,
  input logic [WORD_W-1:0] res_o,
  input logic              res_vld_o,
  input logic              trap_o,
  input logic [FLAG_W-1:0] flags_o
);

  logic res_is_nan;
  assign res_is_nan = (res_o[WORD_W-2 -: EXP_W] == '1) && (res_o[FRAC_W-1:0] != '0);

  // R1
  vld_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> res_vld_o);

  // R1
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> ($stable(res_o) && !res_vld_o));

  // R5
  nan_out_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld_o && res_is_nan) |-> res_o[QUIET_BIT]);

  // R6
  default_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld_o && res_is_nan && $past(dn_mode)) |-> (res_o == CANON_NAN));

  // R8
  upper_flags_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_o >> 1) == '0);

  // R9
  trap_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> ($past(inv_trap_en) && res_vld_o));

  // R9
  trap_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_o && !$past(flag_clr)) |-> (flags_o == $past(flags_o)));

  // R10
  flags_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_clr |=> ((flags_o & $past(flags_o)) == $past(flags_o)));

endmodule

bind fp_minmax_unit fp_minmax_unit_chk #(.FLAG_W(FLAG_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_vld      (in_vld),
  .dn_mode     (dn_mode),
  .inv_trap_en (inv_trap_en),
  .flag_clr    (flag_clr),
  .res_o       (res_o),
  .res_vld_o   (res_vld_o),
  .trap_o      (trap_o),
  .flags_o     (flags_o)
);

// File: tb/fp_minmax_unit_test.sv
module fp_minmax_unit_test;

  localparam int CLK_PERIOD = 10;
  localparam int FW = 5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_vld;
  logic [31:0] opa, opb;
  logic [1:0]  opcode;
  logic        dn_mode, inv_trap_en, flag_clr;
  logic [31:0] res_o;
  logic        res_vld_o, trap_o;
  logic [FW-1:0] flags_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [FW-1:0] exp_flags = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_minmax_unit #(.FLAG_W(FW)) uut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .opa(opa), .opb(opb),
    .opcode(opcode), .dn_mode(dn_mode), .inv_trap_en(inv_trap_en),
    .flag_clr(flag_clr), .res_o(res_o), .res_vld_o(res_vld_o),
    .trap_o(trap_o), .flags_o(flags_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic bit f_nan(input logic [31:0] w);
    return (w[30:23] == 8'hFF) && (w[22:0] != 0);
  endfunction
  function automatic bit f_q(input logic [31:0] w);
    return f_nan(w) && w[22];
  endfunction
  function automatic bit f_s(input logic [31:0] w);
    return f_nan(w) && !w[22];
  endfunction

  // numeric value; infinities mapped to huge magnitudes
  function automatic real f_val(input logic [31:0] w);
    real m, v;
    int  e;
    if (w[30:23] == 8'hFF) v = 1.0e300;
    else begin
      e = (w[30:23] == 0) ? 1 : int'(w[30:23]);
      m = (w[30:23] == 0) ? real'(w[22:0]) : real'(w[22:0]) + 8388608.0;
      v = m * (2.0 ** (e - 150));
    end
    return w[31] ? -v : v;
  endfunction

  task automatic ref_op(input logic [31:0] a_in, b_in, input logic [1:0] op, input bit dn,
                        output logic [31:0] r, output bit inv);
    logic [31:0] a, b, pick;
    bit mn;
    a = a_in; b = b_in; mn = op[0]; inv = 0;
    if (op[1]) begin
      if (f_q(a) && !f_q(b)) a = mn ? 32'h7F800000 : 32'hFF800000;
      else if (f_q(b) && !f_q(a)) b = mn ? 32'h7F800000 : 32'hFF800000;
    end
    if (f_nan(a) || f_nan(b)) begin
      if (f_s(a)) begin r = a | 32'h00400000; inv = 1; end
      else if (f_s(b)) begin r = b | 32'h00400000; inv = 1; end
      else if (f_q(a)) r = a;
      else r = b;
      if (dn) r = 32'h7FC00000;
    end else begin
      if (mn) pick = (f_val(a) < f_val(b)) ? a : b;
      else    pick = (f_val(a) > f_val(b)) ? a : b;
      if (pick[30:0] == 0)
        pick = {mn ? (a[31] | b[31]) : (a[31] & b[31]), 31'd0};
      r = pick;
    end
  endtask

  task automatic do_op(input logic [31:0] a, b, input logic [1:0] op, input bit dn, en, clr,
                       input string tag);
    logic [31:0] r;
    bit inv, trap_exp;
    @(negedge clk);
    in_vld = 1; opa = a; opb = b; opcode = op; dn_mode = dn; inv_trap_en = en; flag_clr = clr;
    @(negedge clk);
    in_vld = 0; flag_clr = 0;
    ref_op(a, b, op, dn, r, inv);
    if (clr) exp_flags = '0;
    trap_exp = inv && en;
    if (inv && !en) exp_flags[0] = 1'b1;
    chk(tag, res_o, r);
    chk("R1 res_vld_o", {31'd0, res_vld_o}, 32'd1);
    chk("R9 trap_o", {31'd0, trap_o}, {31'd0, trap_exp});
    chk("R8/R10 flags_o", {{(32-FW){1'b0}}, flags_o}, {{(32-FW){1'b0}}, exp_flags});
  endtask

  function automatic logic [31:0] rnd_opnd();
    logic s;
    s = 1'($urandom);
    case ($urandom % 8)
      0: return $urandom;
      1: return {s, 31'd0};
      2: return {s, 8'hFF, 23'd0};
      3: return {s, 8'hFF, 1'b1, 22'($urandom)};
      4: return {s, 8'hFF, 1'b0, 22'($urandom) | 22'd1};
      5: return {s, 8'h00, 23'($urandom % 5) | 23'd1};
      default: return {s, 8'd127 + 8'($urandom % 3), 23'($urandom % 4)};
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'd1234));
    rst_n = 0; in_vld = 0; opa = 0; opb = 0; opcode = 0;
    dn_mode = 0; inv_trap_en = 0; flag_clr = 0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 res_o", res_o, 0);
    chk("R11 res_vld_o", {31'd0, res_vld_o}, 0);
    chk("R11 trap_o", {31'd0, trap_o}, 0);
    chk("R11 flags_o", {{(32-FW){1'b0}}, flags_o}, 0);
    rst_n = 1;

    // R2 ordinary values, denormals, infinities
    do_op(32'h3F800000, 32'h40000000, 2'd0, 0, 0, 0, "R2 max 1,2");
    do_op(32'h3F800000, 32'h40000000, 2'd1, 0, 0, 0, "R2 min 1,2");
    do_op(32'hC0000000, 32'h3F800000, 2'd0, 0, 0, 0, "R2 max -2,1");
    do_op(32'h7F800000, 32'hC0400000, 2'd0, 0, 0, 0, "R2 max +inf");
    do_op(32'hFF800000, 32'h3F800000, 2'd1, 0, 0, 0, "R2 min -inf");
    do_op(32'h00000001, 32'h00000002, 2'd0, 0, 0, 0, "R2 max denormals");
    do_op(32'h80000001, 32'h00000001, 2'd1, 0, 0, 0, "R2 min signed denormals");
    // R3 zero signs
    do_op(32'h00000000, 32'h80000000, 2'd0, 0, 0, 0, "R3 max +0,-0");
    do_op(32'h00000000, 32'h80000000, 2'd1, 0, 0, 0, "R3 min +0,-0");
    do_op(32'h80000000, 32'h00000000, 2'd0, 0, 0, 0, "R3 max -0,+0");
    do_op(32'h80000000, 32'h80000000, 2'd0, 0, 0, 0, "R3 max -0,-0");
    // R1 hold while idle
    held = res_o;
    @(negedge clk);
    chk("R1 hold res_o", res_o, held);
    chk("R1 idle res_vld_o", {31'd0, res_vld_o}, 0);
    // R4 R5 NaN priority and quieting
    do_op(32'h7FC00011, 32'h7F800022, 2'd0, 0, 0, 0, "R4 qnan vs snan");
    do_op(32'h7F800005, 32'hFF800007, 2'd1, 0, 0, 0, "R4 two snans");
    do_op(32'h7FC00003, 32'h7FC00009, 2'd0, 0, 0, 0, "R4 two qnans");
    do_op(32'h3F800000, 32'hFFC00001, 2'd0, 0, 0, 0, "R5 qnan payload");
    // R6 default NaN
    do_op(32'h7F800005, 32'h3F800000, 2'd1, 1, 0, 0, "R6 dn snan");
    do_op(32'h3F800000, 32'hFFC12345, 2'd0, 1, 0, 0, "R6 dn qnan");
    // R7 NaN-ignoring
    do_op(32'h7FC00001, 32'h40400000, 2'd2, 0, 0, 0, "R7 maxnum qnan,3");
    do_op(32'hC0000000, 32'h7FC00001, 2'd3, 0, 0, 0, "R7 minnum -2,qnan");
    do_op(32'h7FC00001, 32'hFFC00002, 2'd2, 0, 0, 0, "R7 maxnum two qnans");
    do_op(32'h7FC00001, 32'h7F800003, 2'd2, 0, 0, 0, "R7 maxnum qnan,snan");
    do_op(32'h7FC00001, 32'hFF800000, 2'd3, 0, 0, 0, "R7 minnum qnan,-inf");
    do_op(32'h7FC00001, 32'hFF800000, 2'd2, 0, 0, 0, "R7 maxnum qnan,-inf");
    // R8 R9 R10 flag path
    do_op(32'h00000000, 32'h00000000, 2'd0, 0, 0, 1, "R10 clear");
    do_op(32'h7F800001, 32'h00000000, 2'd1, 0, 1, 0, "R9 trap result");
    @(negedge clk);
    chk("R9 trap one cycle", {31'd0, trap_o}, 0);
    do_op(32'h7F800001, 32'h00000000, 2'd0, 0, 0, 0, "R8 set flag");
    do_op(32'h3F800000, 32'h40000000, 2'd0, 0, 0, 0, "R10 sticky");
    do_op(32'h7F800001, 32'h00000000, 2'd0, 0, 0, 1, "R10 clear with event");
    @(negedge clk);
    flag_clr = 1;
    @(negedge clk);
    flag_clr = 0; exp_flags = '0;
    chk("R10 cleared", {{(32-FW){1'b0}}, flags_o}, 0);

    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a, b;
      a = rnd_opnd(); b = rnd_opnd();
      do_op(a, b, 2'($urandom), ($urandom % 4) == 0, ($urandom % 4) == 0,
            ($urandom % 16) == 0, "R2/R3/R4/R7 random");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule